// File: doc/BRIEF.md
# Processor Interrupt Acceptance Unit

This unit sits next to a small processor core. At instruction boundaries it decides whether the core takes an event, and which one: an architectural reset, a non-maskable interrupt (NMI) or one of six maskable sources. Request lines are caught on their rising edges and held in pending flags until the event can be taken. These flags are shown on status outputs. When the unit accepts an event, it registers a one-cycle redirect. With the redirect it presents the new program counter, status word (PSW) and exception-cause word (ECR). It also presents the old PC and PSW together with a write strobe for the matching shadow-register pair.

The cause word has two halves that are updated separately. NMI acceptance rewrites the upper 16 bits and keeps the lower 16. Maskable acceptance rewrites the lower 16 bits and keeps the upper 16. Only one NMI is ever held, so a storm of NMIs while one is in service collapses into a single later delivery. Maskable requests stay pending while they are blocked. They are served lowest vector first.

Top module: `irq_accept_unit`

## Requirements
- R1: A rising edge on `reset_req` produces, one cycle later, `redirect`=1 with `take_kind`=1, `new_pc`=0, `new_psw`=0x20, `new_ecr`=0 and no save strobe. While `reset_req` is high, all pending flags are cleared, no new request is latched and no NMI or maskable event is taken.
- R2: After `rst_n` all pending flags are 0 and `redirect` is 0. A rising edge on `nmi_req` or on a `mask_req` bit sets the matching pending flag at the next clock.
- R3: An NMI is not taken while `cur_psw` bit 7 (NMI in service) is set. It stays pending, and further NMI edges during that time still leave exactly one NMI pending.
- R4: On NMI acceptance, `save_pc`/`save_psw` carry the `cur_pc`/`cur_psw` of the accepting cycle and `save_nmi_we` pulses for one cycle.
- R5: On NMI acceptance, `new_pc`=0x10. `new_psw` is `cur_psw` with bit 7 set, bit 6 (exception in progress) cleared and bit 5 (interrupt disable) set. `new_ecr` keeps the lower 16 bits of `cur_ecr`, and its upper 16 bits become 0x0010.
- R6: A maskable request is not taken while `cur_psw` bit 7 or bit 5 is set. It stays pending until taken.
- R7: On maskable acceptance, `save_mask_we` pulses with `save_pc`/`save_psw` set to the current values. `new_psw` is `cur_psw` with bit 5 set and bit 6 cleared. `new_ecr` keeps the upper 16 bits of `cur_ecr` and sets the lower 16 bits to the source vector.
- R8: The vector of source i (0..5) is 0x80+0x10*i, giving 0x80, 0x90, 0xA0, 0xB0, 0xC0 and 0xD0. It is used both as `new_pc` and as the ECR lower half, and `take_kind`=3 with `take_src`=i.
- R9: When several maskable flags are pending, the lowest index is taken and only its flag clears. The others stay pending.
- R10: NMI and maskable events are taken only in a cycle with `boundary` high and `redirect` low. Such a redirect is therefore never preceded by another redirect in the cycle before.
- R11: An NMI that may be taken wins over any pending maskable request at the same boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| reset_req | input | 1 | Architectural reset request, acted on at its rising edge |
| nmi_req | input | 1 | Non-maskable request line |
| mask_req | input | NUM_SRC | Maskable request lines, index 0 = overflow timer ... 5 = compare |
| boundary | input | 1 | Instruction-boundary strobe |
| cur_pc | input | 32 | Current program counter |
| cur_psw | input | 32 | Current status word |
| cur_ecr | input | 32 | Current exception-cause word |
| redirect | output | 1 | One-cycle pulse: load the new_* values |
| take_kind | output | 2 | 0 none, 1 reset, 2 NMI, 3 maskable (valid with redirect) |
| take_src | output | SRC_W | Index of the maskable source taken |
| new_pc | output | 32 | Vector for the core's program counter |
| new_psw | output | 32 | Status word to load |
| new_ecr | output | 32 | Cause word to load |
| save_pc | output | 32 | PC to write into the shadow register |
| save_psw | output | 32 | PSW to write into the shadow register |
| save_nmi_we | output | 1 | Write strobe for the NMI shadow pair |
| save_mask_we | output | 1 | Write strobe for the maskable shadow pair |
| nmi_pending | output | 1 | An NMI is held |
| mask_pending | output | NUM_SRC | Maskable requests held |

## Verification
The assertions assume that `cur_psw` is driven by the environment and is stable around the clock edge. They also assume that request lines change only between edges, so each edge assertion sees a clean low-to-high transition. The stimulus changes every input one time unit after the falling edge. It holds the PSW blocking bits for whole stretches of cycles and releases them only between boundary strobes. Because of this, blocked and retried deliveries happen on well-defined cycles. The reference model can then follow them without knowing when the core would really update the PSW.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;

  localparam int WORD_W     = 32;
  localparam int HALF_W     = 16;
  localparam int PSW_ID_BIT = 5;
  localparam int PSW_EP_BIT = 6;
  localparam int PSW_NP_BIT = 7;

  localparam logic [WORD_W-1:0] RESET_PSW = 32'h0000_0020;
  localparam logic [WORD_W-1:0] NMI_PC    = 32'h0000_0010;
  localparam logic [HALF_W-1:0] NMI_CODE  = 16'h0010;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    TAKE_NONE  = 2'd0,
    TAKE_RESET = 2'd1,
    TAKE_NMI   = 2'd2,
    TAKE_MASK  = 2'd3
  } take_e;

  // status word after an NMI is taken: in-service and disable set, exception flag dropped
  function automatic word_t psw_after_nmi(word_t psw);
    word_t r;
    r = psw;
    r[PSW_NP_BIT] = 1'b1;
    r[PSW_EP_BIT] = 1'b0;
    r[PSW_ID_BIT] = 1'b1;
    return r;
  endfunction

  // status word after a maskable source is taken
  function automatic word_t psw_after_mask(word_t psw);
    word_t r;
    r = psw;
    r[PSW_ID_BIT] = 1'b1;
    r[PSW_EP_BIT] = 1'b0;
    return r;
  endfunction

  // NMI cause lives in the upper half; lower half untouched
  function automatic word_t ecr_after_nmi(word_t ecr);
    return {NMI_CODE, ecr[HALF_W-1:0]};
  endfunction

  // maskable cause lives in the lower half; upper half untouched
  function automatic word_t ecr_after_mask(word_t ecr, logic [HALF_W-1:0] code);
    return {ecr[WORD_W-1:HALF_W], code};
  endfunction

  function automatic logic [HALF_W-1:0] mask_vector(int unsigned idx,
                                                    int unsigned base,
                                                    int unsigned step);
    return HALF_W'(base + step * idx);
  endfunction

endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
  parameter int N = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         flush,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);

  logic [N-1:0] prev_q;
  logic [N-1:0] rise;

  assign rise = req & ~prev_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q[i] <= 1'b0;
        pend[i]   <= 1'b0;
      end else begin
        prev_q[i] <= req[i];
        if (flush) pend[i] <= 1'b0;
        else       pend[i] <= (pend[i] & ~clr[i]) | rise[i];
      end
    end

    // a fresh edge outside a flush is always held at the next clock
    assert_edge_latched_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && rise[i]) |=> pend[i]);

    // a flush empties the flag
    assert_flush_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !pend[i]);
  end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_accept_pkg::*;
#(
  parameter  int NUM_SRC = 6,
  localparam int SRC_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               boundary,
  input  logic               busy,
  input  logic               nmi_pend,
  input  logic [NUM_SRC-1:0] mask_pend,
  input  word_t              psw,
  output logic               take_nmi,
  output logic               take_mask,
  output logic [SRC_W-1:0]   mask_idx,
  output logic [NUM_SRC-1:0] mask_clr
);

  logic window;
  logic nmi_open;
  logic mask_open;
  logic any_mask;

  assign window    = boundary & ~busy;
  assign nmi_open  = ~psw[PSW_NP_BIT];
  assign mask_open = ~psw[PSW_NP_BIT] & ~psw[PSW_ID_BIT];

  // lowest index wins: scan from the top so the last hit is the smallest
  always_comb begin
    mask_idx = '0;
    any_mask = 1'b0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (mask_pend[i]) begin
        mask_idx = SRC_W'(i);
        any_mask = 1'b1;
      end
    end
  end

  assign take_nmi  = window & nmi_pend & nmi_open;
  assign take_mask = window & any_mask & mask_open & ~take_nmi;
  assign mask_clr  = take_mask ? (NUM_SRC'(1) << mask_idx) : '0;

endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
  import irq_accept_pkg::*;
#(
  parameter  int NUM_SRC  = 6,
  parameter  int VEC_BASE = 'h80,
  parameter  int VEC_STEP = 'h10,
  localparam int SRC_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reset_req,
  input  logic               nmi_req,
  input  logic [NUM_SRC-1:0] mask_req,
  input  logic               boundary,
  input  logic [31:0]        cur_pc,
  input  logic [31:0]        cur_psw,
  input  logic [31:0]        cur_ecr,
  output logic               redirect,
  output logic [1:0]         take_kind,
  output logic [SRC_W-1:0]   take_src,
  output logic [31:0]        new_pc,
  output logic [31:0]        new_psw,
  output logic [31:0]        new_ecr,
  output logic [31:0]        save_pc,
  output logic [31:0]        save_psw,
  output logic               save_nmi_we,
  output logic               save_mask_we,
  output logic               nmi_pending,
  output logic [NUM_SRC-1:0] mask_pending
);

  // named internal events
  logic               rst_prev_q;
  logic               rst_rise;
  logic               take_nmi;
  logic               take_mask;
  logic [SRC_W-1:0]   mask_idx;
  logic [NUM_SRC-1:0] mask_clr;
  logic [HALF_W-1:0]  mask_code;
  logic               nmi_clr;

  assign rst_rise  = reset_req & ~rst_prev_q;
  assign nmi_clr   = take_nmi & ~reset_req;
  assign mask_code = mask_vector(int'(mask_idx), VEC_BASE, VEC_STEP);

  irq_req_latch #(.N(1)) u_nmi_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (nmi_req),
    .flush (reset_req),
    .clr   (nmi_clr),
    .pend  (nmi_pending)
  );

  irq_req_latch #(.N(NUM_SRC)) u_mask_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (mask_req),
    .flush (reset_req),
    .clr   (mask_clr),
    .pend  (mask_pending)
  );

  irq_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
    .boundary  (boundary & ~reset_req),
    .busy      (redirect),
    .nmi_pend  (nmi_pending),
    .mask_pend (mask_pending),
    .psw       (cur_psw),
    .take_nmi  (take_nmi),
    .take_mask (take_mask),
    .mask_idx  (mask_idx),
    .mask_clr  (mask_clr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_prev_q   <= 1'b0;
      redirect     <= 1'b0;
      take_kind    <= TAKE_NONE;
      take_src     <= '0;
      new_pc       <= '0;
      new_psw      <= '0;
      new_ecr      <= '0;
      save_pc      <= '0;
      save_psw     <= '0;
      save_nmi_we  <= 1'b0;
      save_mask_we <= 1'b0;
    end else begin
      rst_prev_q   <= reset_req;
      redirect     <= 1'b0;
      take_kind    <= TAKE_NONE;
      save_nmi_we  <= 1'b0;
      save_mask_we <= 1'b0;
      if (reset_req) begin
        if (rst_rise) begin
          redirect  <= 1'b1;
          take_kind <= TAKE_RESET;
          new_pc    <= '0;
          new_psw   <= RESET_PSW;
          new_ecr   <= '0;
        end
      end else if (take_nmi) begin
        redirect    <= 1'b1;
        take_kind   <= TAKE_NMI;
        save_pc     <= cur_pc;
        save_psw    <= cur_psw;
        save_nmi_we <= 1'b1;
        new_pc      <= NMI_PC;
        new_psw     <= psw_after_nmi(cur_psw);
        new_ecr     <= ecr_after_nmi(cur_ecr);
      end else if (take_mask) begin
        redirect     <= 1'b1;
        take_kind    <= TAKE_MASK;
        take_src     <= mask_idx;
        save_pc      <= cur_pc;
        save_psw     <= cur_psw;
        save_mask_we <= 1'b1;
        new_pc       <= {{(WORD_W-HALF_W){1'b0}}, mask_code};
        new_psw      <= psw_after_mask(cur_psw);
        new_ecr      <= ecr_after_mask(cur_ecr, mask_code);
      end
    end
  end

  // ---------------- assertions ----------------
  assert_reset_vector_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && take_kind == TAKE_RESET) |->
      (new_pc == '0 && new_psw == RESET_PSW && new_ecr == '0 && !save_nmi_we && !save_mask_we));

  assert_reset_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reset_req) |-> (take_kind == TAKE_NONE || take_kind == TAKE_RESET));

  assert_nmi_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && take_kind == TAKE_NMI) |-> !$past(cur_psw[PSW_NP_BIT]));

  assert_nmi_save_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && take_kind == TAKE_NMI) |->
      (save_nmi_we && !save_mask_we && save_pc == $past(cur_pc) && save_psw == $past(cur_psw)));

  assert_nmi_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && take_kind == TAKE_NMI) |->
      (new_pc == NMI_PC && new_psw[PSW_NP_BIT] && new_psw[PSW_ID_BIT] && !new_psw[PSW_EP_BIT]
       && new_ecr[HALF_W-1:0] == $past(cur_ecr[HALF_W-1:0])));

  assert_mask_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && take_kind == TAKE_MASK) |->
      (!$past(cur_psw[PSW_NP_BIT]) && !$past(cur_psw[PSW_ID_BIT])));

  assert_mask_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && take_kind == TAKE_MASK) |->
      (save_mask_we && !save_nmi_we && new_psw[PSW_ID_BIT] && !new_psw[PSW_EP_BIT]
       && new_ecr[WORD_W-1:HALF_W] == $past(cur_ecr[WORD_W-1:HALF_W])
       && new_ecr[HALF_W-1:0] == new_pc[HALF_W-1:0]));

  assert_one_taken_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && take_kind == TAKE_MASK) |->
      ($countones($past(mask_pending) & ~mask_pending) == 1));

  assert_boundary_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && take_kind != TAKE_RESET) |-> ($past(boundary) && !$past(redirect)));

  assert_save_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({save_nmi_we, save_mask_we}));

  assert_nmi_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && take_kind == TAKE_MASK) |->
      !($past(nmi_pending) && !$past(cur_psw[PSW_NP_BIT])));

endmodule

// File: tb/test_irq_accept_unit.sv
module test_irq_accept_unit;

  localparam int NSRC = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reset_req = 1'b0;
  logic        nmi_req = 1'b0;
  logic [5:0]  mask_req = '0;
  logic        boundary = 1'b0;
  logic [31:0] cur_pc = '0;
  logic [31:0] cur_psw = '0;
  logic [31:0] cur_ecr = '0;

  logic        redirect;
  logic [1:0]  take_kind;
  logic [2:0]  take_src;
  logic [31:0] new_pc, new_psw, new_ecr, save_pc, save_psw;
  logic        save_nmi_we, save_mask_we, nmi_pending;
  logic [5:0]  mask_pending;

  irq_accept_unit i_irq_accept_unit (
    .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .nmi_req(nmi_req),
    .mask_req(mask_req), .boundary(boundary), .cur_pc(cur_pc), .cur_psw(cur_psw),
    .cur_ecr(cur_ecr), .redirect(redirect), .take_kind(take_kind), .take_src(take_src),
    .new_pc(new_pc), .new_psw(new_psw), .new_ecr(new_ecr), .save_pc(save_pc),
    .save_psw(save_psw), .save_nmi_we(save_nmi_we), .save_mask_we(save_mask_we),
    .nmi_pending(nmi_pending), .mask_pending(mask_pending)
  );

  always #4 clk = ~clk;   // 125 MHz

  int    tests = 0;
  int    fails = 0;
  string tag = "R2";
  bit    done = 1'b0;

  // ---------------- behavioural reference model ----------------
  int  m_redir, m_kind, m_src, m_wen, m_wem, m_np;
  int  m_mp[NSRC];
  int  m_pc, m_psw, m_ecr, m_spc, m_spsw;
  int  p_rst, p_nmi;
  int  p_m[NSRC];

  initial begin
    m_redir = 0; m_kind = 0; m_src = 0; m_wen = 0; m_wem = 0; m_np = 0;
    m_pc = 0; m_psw = 0; m_ecr = 0; m_spc = 0; m_spsw = 0; p_rst = 0; p_nmi = 0;
    foreach (m_mp[i]) begin m_mp[i] = 0; p_m[i] = 0; end
  end

  always @(posedge clk) begin
    int busy, taken, blk_np, blk_id;
    if (!rst_n) begin
      m_redir = 0; m_kind = 0; m_src = 0; m_wen = 0; m_wem = 0; m_np = 0;
      m_pc = 0; m_psw = 0; m_ecr = 0; m_spc = 0; m_spsw = 0; p_rst = 0; p_nmi = 0;
      foreach (m_mp[i]) begin m_mp[i] = 0; p_m[i] = 0; end
    end else begin
      busy = m_redir;
      m_redir = 0; m_kind = 0; m_wen = 0; m_wem = 0;
      blk_np = cur_psw[7];
      blk_id = cur_psw[5];
      if (reset_req) begin
        m_np = 0;
        foreach (m_mp[i]) m_mp[i] = 0;
        if (p_rst == 0) begin
          m_redir = 1; m_kind = 1; m_pc = 0; m_psw = 'h20; m_ecr = 0;
        end
      end else begin
        taken = 0;
        if (boundary && !busy && m_np && !blk_np) begin
          m_redir = 1; m_kind = 2; m_wen = 1; m_np = 0;
          m_spc = cur_pc; m_spsw = cur_psw;
          m_pc = 'h10;
          m_psw = (cur_psw | 'h80 | 'h20) & ~'h40;
          m_ecr = (cur_ecr & 'hFFFF) | 'h0010_0000;
          taken = 1;
        end
        if (!taken && boundary && !busy && !blk_np && !blk_id) begin
          for (int i = 0; i < NSRC; i++) begin
            if (!taken && m_mp[i]) begin
              taken = 1; m_mp[i] = 0;
              m_redir = 1; m_kind = 3; m_wem = 1; m_src = i;
              m_spc = cur_pc; m_spsw = cur_psw;
              m_pc = 'h80 + 'h10 * i;
              m_psw = (cur_psw | 'h20) & ~'h40;
              m_ecr = (cur_ecr & 'hFFFF_0000) | m_pc;
            end
          end
        end
        if (nmi_req && !p_nmi) m_np = 1;
        for (int i = 0; i < NSRC; i++) if (mask_req[i] && !p_m[i]) m_mp[i] = 1;
      end
      p_rst = reset_req;
      p_nmi = nmi_req;
      for (int i = 0; i < NSRC; i++) p_m[i] = mask_req[i];
    end
  end

  task automatic chk(string field, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, field, act, exp);
    end
  endtask

  // compare every cycle, at the falling edge, before any input moves
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [5:0] mp;
      for (int i = 0; i < NSRC; i++) mp[i] = (m_mp[i] != 0);
      chk("redirect", {31'b0, redirect}, m_redir);
      chk("kind", {30'b0, take_kind}, m_kind);
      chk("pending", {25'b0, nmi_pending, mask_pending}, {25'b0, m_np[0], mp});
      chk("save_we", {30'b0, save_nmi_we, save_mask_we}, {30'b0, m_wen[0], m_wem[0]});
      if (m_redir != 0) begin
        chk("new_pc", new_pc, m_pc);
        chk("new_psw", new_psw, m_psw);
        chk("new_ecr", new_ecr, m_ecr);
        if (m_kind == 3) chk("src", {29'b0, take_src}, m_src);
        if (m_kind >= 2) begin
          chk("save_pc", save_pc, m_spc);
          chk("save_psw", save_psw, m_spsw);
        end
      end
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic pulse_nmi();
    nmi_req = 1'b1; cyc(); nmi_req = 1'b0; cyc();
  endtask

  task automatic pulse_mask(logic [5:0] m);
    mask_req = m; cyc(); mask_req = '0; cyc();
  endtask

  task automatic strobe(int n = 1);
    boundary = 1'b1; cyc(n); boundary = 1'b0; cyc(2);
  endtask

  initial begin
    cyc(3);
    // reset state of the flags and strobes
    tag = "R2";
    chk("rst_redirect", {31'b0, redirect}, 0);
    chk("rst_pending", {25'b0, nmi_pending, mask_pending}, 0);
    rst_n = 1'b1;
    cyc(2);

    // R4/R5: plain NMI delivery
    tag = "R4";
    cur_pc = 32'h0000_1234; cur_psw = 32'h0000_0041; cur_ecr = 32'hABCD_5678;
    pulse_nmi();
    strobe();
    tag = "R5";
    cur_psw = 32'h0000_0000; cur_ecr = 32'h1111_2222;
    pulse_nmi();
    strobe();

    // R3: NMIs while one is in service collapse to one
    tag = "R3";
    cur_psw = 32'h0000_0080;
    pulse_nmi(); pulse_nmi(); pulse_nmi();
    strobe(3);
    cur_psw = 32'h0000_0000;
    strobe();
    strobe();

    // R6: masked request waits on ID, then on NP
    tag = "R6";
    cur_psw = 32'h0000_0020;
    pulse_mask(6'b000100);
    strobe(2);
    cur_psw = 32'h0000_0080;
    strobe(2);
    cur_psw = 32'h0000_0000; cur_pc = 32'h0000_4000;
    strobe();

    // R7: cause upper half preserved
    tag = "R7";
    cur_ecr = 32'hDEAD_BEEF; cur_psw = 32'h0000_0040; cur_pc = 32'h0000_0ABC;
    pulse_mask(6'b000001);
    strobe();
    cur_psw = 32'h0000_0000;

    // R8: every vector on its own
    tag = "R8";
    for (int i = 0; i < NSRC; i++) begin
      cur_pc = 32'h100 + i;
      pulse_mask(6'b1 << i);
      strobe();
    end

    // R9: three at once, lowest first, boundary held
    tag = "R9";
    pulse_mask(6'b101010);
    strobe(8);

    // R10: no boundary, no delivery; held boundary spaced by a gap
    tag = "R10";
    pulse_mask(6'b010001);
    cyc(5);
    strobe(4);

    // R11: NMI and maskable together
    tag = "R11";
    nmi_req = 1'b1; mask_req = 6'b000001; cyc();
    nmi_req = 1'b0; mask_req = '0; cyc();
    strobe(3);

    // R1: reset request flushes flags and vectors to zero
    tag = "R1";
    cur_ecr = 32'hFFFF_FFFF;
    pulse_nmi();
    pulse_mask(6'b111111);
    reset_req = 1'b1; cyc();
    nmi_req = 1'b1; mask_req = 6'b000011; boundary = 1'b1;
    cyc(3);
    nmi_req = 1'b0; mask_req = '0;
    reset_req = 1'b0; boundary = 1'b0;
    cyc(2);
    chk("flushed", {25'b0, nmi_pending, mask_pending}, 0);
    strobe();
    cyc(4);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      tests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule